// File: doc/BRIEF.md
# Access-Size Endianness Lane Swapper

This block changes the lane order of a data word between big-endian and little-endian form, together with the byte mask that goes with it. The reversal is confined to naturally aligned chunks whose length equals the memory access size. The word is cut into consecutive chunks that start at byte 0. The byte order is reversed inside each chunk, and the same change is made in every chunk across the word. The mask has one bit per data byte and goes through the same permutation, with each bit treated as if it were a byte.

A load/store datapath places the block in front of a byte-granular merge or bypass stage, so that stored data, loaded data and byte-hit masks all share one lane order. A second instance with the same size code restores the original order. The block is purely combinational. The word width is a parameter and must be a power-of-two number of bytes.

Top module: `lane_order_swap`

## Requirements
- R1: The 2-bit size code `k` selects a chunk of 2^k bytes (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). With code 0, `data_out` equals `data_in` and `mask_out` equals `mask_in`.
- R2: With code 1, bytes 2i and 2i+1 of the word trade places for every i.
- R3: With code 2, each group of bytes 4i..4i+3 is reversed on its own. Output byte 4i+j takes input byte 4i+3-j.
- R4: With code 3 on a 64-bit word, the whole word is byte-reversed. Output byte j takes input byte 7-j.
- R5: For any supported chunk size N and any word width, output byte j takes input byte (j - j mod N) + (N-1 - j mod N).
- R6: Mask bit j of the output takes the mask bit at the same source index that output data byte j takes. The number of set mask bits is therefore preserved.
- R7: A size code whose chunk is wider than the word (code 3 on a 32-bit word) leaves both data and mask unchanged.
- R8: Applying the block twice with the same size code returns the original data and mask.
- R9: The outputs depend only on the present inputs. They settle within the same cycle the inputs change, with no clock and no held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | DATA_W | Word to be re-ordered |
| mask_in | input | DATA_W/8 | One valid bit per byte of `data_in` |
| size_code | input | 2 | Access size: 2^code bytes |
| data_out | output | DATA_W | Word with bytes reversed inside each chunk |
| mask_out | output | DATA_W/8 | Mask permuted like the data bytes |

## Verification
The assertions are evaluated on every input change. They check the 1-byte pass-through, the exchange of byte pairs, the full-word reversal, the pass-through for unsupported codes, and that the number of set mask bits is preserved. The bench's scenarios are needed to show the exact lane mapping for 4-byte chunks, the general chunk formula at two word widths, that the mask follows the data byte for byte, and that a second swap restores the input. These rest on a reference model driven with directed and random words.

// File: rtl/lane_swap_pkg.sv
// Package: shared size encoding and helpers for the lane-order swapper.
// Assumes size codes are 2 bits wide and name power-of-two chunk lengths.
package lane_swap_pkg;

    // Access size encoding: code k selects a chunk of 2^k bytes.
    typedef enum logic [1:0] {
        ACC_1B = 2'd0,
        ACC_2B = 2'd1,
        ACC_4B = 2'd2,
        ACC_8B = 2'd3
    } acc_size_e;

    // Number of distinct size codes.
    localparam int unsigned NUM_ACC = 4;

    // Chunk length in bytes for a size code.
    function automatic int unsigned acc_bytes(input logic [1:0] code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/chunk_rev.sv
// Module: chunk_rev
// Reverses the order of ELEM_W-bit elements inside each aligned group of
// CHUNK elements, repeated over the whole vector. Pure wiring.
// Assumes CHUNK divides N_ELEM and CHUNK >= 1.
module chunk_rev #(
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned N_ELEM = 8,
    parameter int unsigned CHUNK  = 2
) (
    input  logic [ELEM_W*N_ELEM-1:0] vec_in,
    output logic [ELEM_W*N_ELEM-1:0] vec_out
);
    localparam int unsigned NCHUNK = N_ELEM / CHUNK;

    // Each output element takes its mirror image inside the same chunk.
    for (genvar c = 0; c < NCHUNK; c++) begin : g_chunk
        for (genvar e = 0; e < CHUNK; e++) begin : g_elem
            assign vec_out[(c*CHUNK + e)*ELEM_W +: ELEM_W] =
                vec_in[(c*CHUNK + CHUNK - 1 - e)*ELEM_W +: ELEM_W];
        end
    end

endmodule

// File: rtl/size_decode.sv
// Module: size_decode
// Turns the 2-bit size code into a one-hot chunk select. The select stays
// all-zero when the chunk would be wider than the word.
// Assumes NBYTES is a power of two.
module size_decode
    import lane_swap_pkg::*;
#(
    parameter int unsigned NBYTES = 8
) (
    input  logic [1:0]         size_code,
    output logic [NUM_ACC-1:0] sel_onehot,
    output logic               supported
);
    // Decide whether the code fits the word, and flag the selected chunk size.
    always_comb begin
        supported  = (acc_bytes(size_code) <= NBYTES);
        sel_onehot = '0;
        if (supported) begin
            sel_onehot[size_code] = 1'b1;
        end
    end

endmodule

// File: rtl/swap_plane.sv
// Module: swap_plane
// Builds one chunk-reversed candidate for each chunk size that fits
// N_ELEM, then picks one with a one-hot select. With no select bit set
// the input passes through. Used for the data bytes and the mask bits.
// Assumes sel has at most one bit set.
module swap_plane
    import lane_swap_pkg::*;
#(
    parameter int unsigned ELEM_W = 8,
    parameter int unsigned N_ELEM = 8
) (
    input  logic [ELEM_W*N_ELEM-1:0] plane_in,
    input  logic [NUM_ACC-1:0]       sel,
    output logic [ELEM_W*N_ELEM-1:0] plane_out
);
    localparam int unsigned PW = ELEM_W * N_ELEM;

    logic [PW-1:0] cand [NUM_ACC];

    for (genvar k = 0; k < NUM_ACC; k++) begin : g_size
        if ((32'd1 << k) <= N_ELEM) begin : g_fit
            chunk_rev #(
                .ELEM_W (ELEM_W),
                .N_ELEM (N_ELEM),
                .CHUNK  (32'd1 << k)
            ) u_rev (
                .vec_in  (plane_in),
                .vec_out (cand[k])
            );
        end else begin : g_nofit
            assign cand[k] = plane_in;
        end
    end

    // Select the candidate for the active size, default pass-through.
    always_comb begin
        plane_out = plane_in;
        for (int k = 0; k < NUM_ACC; k++) begin
            if (sel[k]) plane_out = cand[k];
        end
    end

endmodule

// File: rtl/lane_order_swap.sv
// Module: lane_order_swap (top)
// Converts a word and its per-byte mask between big- and little-endian
// lane order within access-size chunks. Purely combinational.
// Assumes DATA_W is 8 times a power of two; unsupported codes pass through.
module lane_order_swap
    import lane_swap_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic [DATA_W-1:0]   data_in,
    input  logic [DATA_W/8-1:0] mask_in,
    input  logic [1:0]          size_code,
    output logic [DATA_W-1:0]   data_out,
    output logic [DATA_W/8-1:0] mask_out
);
    localparam int unsigned NBYTES = DATA_W / 8;

    logic [NUM_ACC-1:0] sel;
    logic               supported;

    size_decode #(.NBYTES(NBYTES)) u_dec (
        .size_code  (size_code),
        .sel_onehot (sel),
        .supported  (supported)
    );

    swap_plane #(.ELEM_W(8), .N_ELEM(NBYTES)) u_data (
        .plane_in  (data_in),
        .sel       (sel),
        .plane_out (data_out)
    );

    swap_plane #(.ELEM_W(1), .N_ELEM(NBYTES)) u_mask (
        .plane_in  (mask_in),
        .sel       (sel),
        .plane_out (mask_out)
    );

    // The support flag is implied by sel; kept for observation.
    logic unused_ok;
    assign unused_ok = supported;

endmodule

// File: rtl/lane_order_swap_chk.sv
// Module: lane_order_swap_chk
// Immediate checks on the swapper's ports, evaluated whenever they change.
// Bound to every lane_order_swap instance.
module lane_order_swap_chk #(
    parameter int unsigned DATA_W = 64
) (
    input logic [DATA_W-1:0]   data_in,
    input logic [DATA_W/8-1:0] mask_in,
    input logic [1:0]          size_code,
    input logic [DATA_W-1:0]   data_out,
    input logic [DATA_W/8-1:0] mask_out
);
    localparam int unsigned NB = DATA_W / 8;

    // Port-level properties of the permutation.
    always_comb begin
        if (size_code == 2'd0) begin
            p_passthru_r1: assert (data_out == data_in && mask_out == mask_in);
        end
        if ((32'd1 << size_code) > NB) begin
            p_unsupported_r7: assert (data_out == data_in && mask_out == mask_in);
        end
        p_mask_weight_r6: assert ($countones(mask_out) == $countones(mask_in));
        if (size_code == 2'd1) begin
            for (int i = 0; i < NB; i++) begin
                p_pair_r2: assert (data_out[i*8 +: 8] == data_in[(i ^ 1)*8 +: 8]);
            end
        end
        if ((32'd1 << size_code) == NB) begin
            for (int i = 0; i < NB; i++) begin
                p_full_rev_r4: assert (data_out[i*8 +: 8] == data_in[(NB-1-i)*8 +: 8]);
            end
        end
    end

endmodule

bind lane_order_swap lane_order_swap_chk #(.DATA_W(DATA_W)) u_chk (
    .data_in   (data_in),
    .mask_in   (mask_in),
    .size_code (size_code),
    .data_out  (data_out),
    .mask_out  (mask_out)
);

// File: tb/sim_lane_order_swap.sv
module sim_lane_order_swap;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // 64-bit instance under test
    logic [63:0] d_in, d_out;
    logic [7:0]  m_in, m_out;
    logic [1:0]  code;
    lane_order_swap #(.DATA_W(64)) u0 (
        .data_in(d_in), .mask_in(m_in), .size_code(code),
        .data_out(d_out), .mask_out(m_out));

    // 32-bit instance for width-dependent behaviour
    logic [31:0] e_in, e_out;
    logic [3:0]  n_in, n_out;
    logic [1:0]  code32;
    lane_order_swap #(.DATA_W(32)) u1 (
        .data_in(e_in), .mask_in(n_in), .size_code(code32),
        .data_out(e_out), .mask_out(n_out));

    // Reference: source index of output lane j for chunk size n.
    function automatic int src_idx(input int j, input int n);
        return (j - (j % n)) + (n - 1 - (j % n));
    endfunction

    function automatic logic [63:0] ref_data(input logic [63:0] d, input int nb, input int c);
        logic [63:0] r = d;
        int n = 1 << c;
        if (n <= nb)
            for (int j = 0; j < nb; j++) r[j*8 +: 8] = d[src_idx(j, n)*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] ref_mask(input logic [7:0] m, input int nb, input int c);
        logic [7:0] r = m;
        int n = 1 << c;
        if (n <= nb)
            for (int j = 0; j < nb; j++) r[j] = m[src_idx(j, n)];
        return r;
    endfunction

    task automatic chk(input string req, input logic [63:0] act_d, input logic [63:0] exp_d,
                       input logic [7:0] act_m, input logic [7:0] exp_m);
        checks++;
        if (act_d !== exp_d || act_m !== exp_m) begin
            failures++;
            $display("FAIL %s data=%h mask=%b expected data=%h mask=%b",
                     req, act_d, act_m, exp_d, exp_m);
        end
    endtask

    // Drive 64-bit inputs away from the edge, sample just after the next edge.
    task automatic apply64(input logic [63:0] d, input logic [7:0] m, input logic [1:0] c);
        @(negedge clk);
        d_in = d; m_in = m; code = c;
        @(posedge clk); #1;
    endtask

    task automatic apply32(input logic [31:0] d, input logic [3:0] m, input logic [1:0] c);
        @(negedge clk);
        e_in = d; n_in = m; code32 = c;
        @(posedge clk); #1;
    endtask

    localparam logic [63:0] RAMP = 64'h0706050403020100;

    initial begin
        d_in = '0; m_in = '0; code = 2'd0;
        e_in = '0; n_in = '0; code32 = 2'd0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        // R9: zero in gives zero out with no clocked state
        chk("R9 idle", d_out, 64'h0, m_out, 8'h0);

        apply64(RAMP, 8'b0000_0001, 2'd0);
        chk("R1 one-byte pass", d_out, RAMP, m_out, 8'b0000_0001);
        apply64(RAMP, 8'b0000_0001, 2'd1);
        chk("R2 pair swap", d_out, 64'h0607040502030001, m_out, 8'b0000_0010);
        apply64(RAMP, 8'b0000_0001, 2'd2);
        chk("R3 quad reverse", d_out, 64'h0405060700010203, m_out, 8'b0000_1000);
        apply64(RAMP, 8'b0000_0001, 2'd3);
        chk("R4 full reverse", d_out, 64'h0001020304050607, m_out, 8'b1000_0000);
        apply64(64'hDEAD_BEEF_0123_4567, 8'b1100_0110, 2'd2);
        chk("R6 mask follows data", d_out, 64'hEFBE_ADDE_6745_2301, m_out, 8'b0011_0110);

        // R7: 8-byte code on a 32-bit word is unsupported
        apply32(32'h0302_0100, 4'b0011, 2'd3);
        chk("R7 unsupported", {32'h0, e_out}, 64'h0302_0100, {4'h0, n_out}, 8'b0011);
        apply32(32'h0302_0100, 4'b0001, 2'd2);
        chk("R5 32-bit full", {32'h0, e_out}, 64'h0001_0203, {4'h0, n_out}, 8'b1000);

        // R5/R6/R8: random words, every code, both widths
        for (int c = 0; c < 4; c++) begin
            for (int t = 0; t < 40; t++) begin
                logic [63:0] d;
                logic [7:0]  m;
                logic [63:0] first_d;
                logic [7:0]  first_m;
                d = {$urandom, $urandom};
                m = 8'($urandom);
                apply64(d, m, 2'(c));
                chk("R5 R6 random 64", d_out, ref_data(d, 8, c), m_out, ref_mask(m, 8, c));
                first_d = d_out; first_m = m_out;
                apply64(first_d, first_m, 2'(c));
                chk("R8 double swap", d_out, d, m_out, m);
                apply32(d[31:0], m[3:0], 2'(c));
                chk("R5 R7 random 32", {32'h0, e_out}, ref_data({32'h0, d[31:0]}, 4, c),
                    {4'h0, n_out}, ref_mask({4'h0, m[3:0]}, 4, c));
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule